// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block models a synchronous static memory that keeps a shared data bus busy on every clock. Reads and writes may follow each other in any order with no idle cycle in between. The trick is a late-late write: a write presents its address and byte enables on one rising edge, and its data follows two rising edges later. Read data also appears two edges after its address, so both directions use the bus in the same slot. The address and control inputs are all registered. An active-low clock enable freezes the whole block. Three chip enables gate each new cycle. Byte-lane write strobes select which 9-bit lanes a write changes.

A cycle is started only when the load strobe is low. While the load strobe is high, the block stays in a burst of the cycle type last loaded. A two-bit beat counter steps the low address bits through four beats, in either linear or interleaved order. The linear/interleaved order comes from a static mode input.

Writes stay coherent while they are in flight. The array is read one edge before the read data is registered out. At that moment, the write that is about to commit gets its data lanes forwarded straight from the write-data input. A read issued right after a write to the same word therefore returns the new bytes. Data in and data out are separate ports.

Top module: `zbt_sram`

## Requirements
- R1: A write whose address and strobes are sampled on enabled edge N takes its data from `wdata` on enabled edge N+2 and stores it at that address.
- R2: A read whose address is sampled on enabled edge N puts the word on `rdata` with `rvalid` high after enabled edge N+2.
- R3: The cycle type is decided only on edges with `ld_n` low (`we_n` high = read, low = write). On edges with `ld_n` high, `we_n` is ignored and the previous type continues.
- R4: A new cycle is active only if `ce0_n`=0, `ce1`=1 and `ce2_n`=0 on the load edge. Any other combination makes a deselect: nothing is written and no data is returned.
- R5: While `cke_n` is high, the edge is ignored. Every pipeline stage, `rdata` and `rvalid` hold their values, and the held edge does not count toward any latency.
- R6: Strobe bit `bw_n[i]`=0 writes bits [9i+8:9i] of the word; lanes whose strobe is 1 keep their old contents. Strobes are sampled with the address, on every write beat.
- R7: A read issued on the edge right after a write to the same word returns the bytes of that write. Unwritten lanes return the older contents.
- R8: With `linear`=1, beat k of a burst (k=0..3) uses low address bits (start+k) mod 4. The upper address bits keep the loaded value.
- R9: With `linear`=0, beat k of a burst uses low address bits start XOR k. The upper address bits keep the loaded value.
- R10: After an enabled edge that completes a write or a deselect, `rvalid` is low.
- R11: After reset, `rvalid` and `rdata` are zero and the pipeline holds no cycle.
- R12: Reads and writes may alternate on consecutive edges with no idle cycle, and each read returns correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_n | input | 1 | Clock enable, active low; high holds everything |
| ld_n | input | 1 | Low: load a new address and cycle type; high: advance the burst |
| we_n | input | 1 | Cycle type on load: high read, low write |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| addr | input | ADDR_W | Word address |
| bw_n | input | LANES | Byte-lane write strobes, active low |
| wdata | input | LANES*LANE_W | Write data, two edges after its address |
| linear | input | 1 | Burst order: 1 linear, 0 interleaved (static) |
| rdata | output | LANES*LANE_W | Registered read data |
| rvalid | output | 1 | High while `rdata` holds data of a completed read |

## Verification
The bench uses a 16-word configuration and tries the main function with several patterns:

- **Full-word sweep.** Writes every address back to back, then reads every address back to back. This shows that address, data and the two-edge latency line up.
- **Strobe sweep.** Runs all sixteen strobe patterns over one word. This tells apart a lane that was wrongly written from one that was wrongly kept.
- **Write/read alternation.** Alternates writes and reads on the same word on consecutive edges. This separates forwarded data from stale array contents.
- **Chip-enable sweep.** Tries all eight chip-enable combinations for both writes and reads. Only one combination may take effect.
- **Burst runs.** Runs bursts in both orders from unaligned starting addresses. Toggling the write input mid-burst shows that the address order is right and that the cycle type cannot change without a load.
- **Stalled edges.** Inserts stalls while a read is in flight. This shows that a held edge neither advances the pipeline nor changes the outputs.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low two address bits for a given beat of a four-beat burst
    function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                               input logic [1:0] beat,
                                               input logic       lin);
        return lin ? (start + beat) : (start ^ beat);
    endfunction

    // Cycle type decided on a load edge
    function automatic op_e decode_op(input logic c0_n, input logic c1,
                                      input logic c2_n, input logic rd_wr_n);
        if (c0_n || !c1 || c2_n)
            return OP_IDLE;
        return rd_wr_n ? OP_READ : OP_WRITE;
    endfunction

endpackage

// File: rtl/zbt_ctl.sv
module zbt_ctl
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              ld_n,
    input  logic              we_n,
    input  logic              ce0_n,
    input  logic              ce1,
    input  logic              ce2_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  bw_n,
    input  logic              linear,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output op_e               s2_op,
    output logic [ADDR_W-1:0] s2_addr,
    output logic [LANES-1:0]  s2_be
);

    logic [ADDR_W-1:0] base_q, nxt_base, nxt_addr;
    logic [1:0]        beat_q, nxt_beat;
    logic [LANES-1:0]  s1_be;
    op_e               nxt_op;

    always_comb begin
        if (!ld_n) begin
            nxt_op   = decode_op(ce0_n, ce1, ce2_n, we_n);
            nxt_beat = 2'd0;
            nxt_base = addr;
            nxt_addr = addr;
        end else begin
            nxt_op   = s1_op;
            nxt_beat = beat_q + 2'd1;
            nxt_base = base_q;
            nxt_addr = {base_q[ADDR_W-1:2],
                        beat_offset(base_q[1:0], nxt_beat, linear)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_op   <= OP_IDLE;
            s2_op   <= OP_IDLE;
            s1_addr <= '0;
            s2_addr <= '0;
            s1_be   <= '0;
            s2_be   <= '0;
            base_q  <= '0;
            beat_q  <= '0;
        end else if (step) begin
            s1_op   <= nxt_op;
            s1_addr <= nxt_addr;
            s1_be   <= ~bw_n;
            base_q  <= nxt_base;
            beat_q  <= nxt_beat;
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_be   <= s1_be;
        end
    end

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    step,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_be,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic same_word;
    assign same_word = wr_en && (wr_addr == rd_addr);

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];
        logic [LANE_W-1:0] merged;

        // Forward the lane of the write committing on this same edge
        always_comb begin
            if (same_word && wr_be[ln])
                merged = wdata[ln*LANE_W +: LANE_W];
            else
                merged = bank[rd_addr];
        end

        always_ff @(posedge clk) begin
            if (step) begin
                if (wr_en && wr_be[ln])
                    bank[wr_addr] <= wdata[ln*LANE_W +: LANE_W];
                if (rd_en)
                    rd_data[ln*LANE_W +: LANE_W] <= merged;
            end
        end
    end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cke_n,
    input  logic                    ld_n,
    input  logic                    we_n,
    input  logic                    ce0_n,
    input  logic                    ce1,
    input  logic                    ce2_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        bw_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    linear,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);

    localparam int WORD_W = LANES * LANE_W;

    logic              step;
    op_e               s1_op, s2_op;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [LANES-1:0]  s2_be;
    logic [WORD_W-1:0] rd_q;

    assign step = !cke_n;

    zbt_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
        .clk(clk), .rst(rst), .step(step), .ld_n(ld_n), .we_n(we_n),
        .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n), .addr(addr), .bw_n(bw_n),
        .linear(linear), .s1_op(s1_op), .s1_addr(s1_addr),
        .s2_op(s2_op), .s2_addr(s2_addr), .s2_be(s2_be)
    );

    zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .step(step),
        .rd_en(s1_op == OP_READ), .rd_addr(s1_addr),
        .wr_en(s2_op == OP_WRITE), .wr_addr(s2_addr), .wr_be(s2_be),
        .wdata(wdata), .rd_data(rd_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else if (step) begin
            rvalid <= (s2_op == OP_READ);
            if (s2_op == OP_READ)
                rdata <= rd_q;
        end
    end

endmodule

module zbt_sram_chk #(
    parameter int WORD_W = 36
) (
    input logic              clk,
    input logic              rst,
    input logic              cke_n,
    input logic              ld_n,
    input logic              ce0_n,
    input logic              ce1,
    input logic              ce2_n,
    input logic [1:0]        s1_op,
    input logic [1:0]        s2_op,
    input logic [WORD_W-1:0] rdata,
    input logic              rvalid
);

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && s2_op == 2'd1) |=> rvalid); // R2

    AST_NONREAD_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && s2_op != 2'd1) |=> !rvalid); // R10

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        cke_n |=> ($stable(rdata) && $stable(rvalid) && $stable(s1_op) && $stable(s2_op))); // R5

    AST_DESELECT: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && !ld_n && (ce0_n || !ce1 || ce2_n)) |=> (s1_op == 2'd0)); // R4

    AST_BURST_KEEPS_TYPE: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && ld_n) |=> $stable(s1_op)); // R3

    AST_PIPE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        !cke_n |=> (s2_op == $past(s1_op))); // R1

endmodule

bind zbt_sram zbt_sram_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst(rst), .cke_n(cke_n), .ld_n(ld_n),
    .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n),
    .s1_op(s1_op), .s2_op(s2_op), .rdata(rdata), .rvalid(rvalid)
);

// File: tb/zbt_sram_bench.sv
`timescale 1ns/1ps
module zbt_sram_bench;

    localparam int AW = 4;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int W  = LN * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst, cke_n, ld_n, we_n, ce0_n, ce1, ce2_n, linear;
    logic [AW-1:0] addr;
    logic [LN-1:0] bw_n;
    logic [W-1:0]  wdata, rdata;
    logic          rvalid;

    always #4 clk = ~clk;

    zbt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_zbt_sram (
        .clk(clk), .rst(rst), .cke_n(cke_n), .ld_n(ld_n), .we_n(we_n),
        .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n), .addr(addr), .bw_n(bw_n),
        .wdata(wdata), .linear(linear), .rdata(rdata), .rvalid(rvalid)
    );

    int     n_cmp = 0;
    int     n_bad = 0;
    int     wd_k  = 1;
    bit     done  = 0;
    string  tag;

    // Spec-level model: ops 0 idle, 1 read, 2 write
    logic [W-1:0]  ref_mem [DEPTH];
    int            p1_op = 0, p2_op = 0;
    logic [AW-1:0] p1_a = '0, p2_a = '0, base = '0;
    logic [LN-1:0] p1_be = '0, p2_be = '0;
    logic [1:0]    beat = '0;
    logic [W-1:0]  exp_d = '0;
    logic          exp_v = 1'b0;

    function automatic logic [W-1:0] gen(input int k);
        logic [31:0] h;
        h = 32'(k) * 32'h9E37_79B1;
        return {4'(k), h ^ 32'(k << 11)};
    endfunction

    task automatic model_edge(input logic l, input logic w, input logic c0n,
                              input logic c1v, input logic c2n,
                              input logic [AW-1:0] a, input logic [LN-1:0] bwn);
        if (p2_op == 1) begin
            exp_v = 1'b1;
            exp_d = ref_mem[p2_a];
        end else begin
            exp_v = 1'b0;
        end
        if (p2_op == 2)
            for (int i = 0; i < LN; i++)
                if (p2_be[i]) ref_mem[p2_a][i*LW +: LW] = wdata[i*LW +: LW];
        p2_op = p1_op; p2_a = p1_a; p2_be = p1_be;
        if (!l) begin
            p1_op = (c0n || !c1v || c2n) ? 0 : (w ? 1 : 2);
            p1_a  = a; base = a; beat = 2'd0;
        end else begin
            beat = beat + 2'd1;
            p1_a = {base[AW-1:2], linear ? base[1:0] + beat : base[1:0] ^ beat};
        end
        p1_be = ~bwn;
    endtask

    task automatic check_out();
        n_cmp++;
        if (rvalid !== exp_v) begin
            n_bad++;
            $display("FAIL %s: rvalid=%0b expected %0b", tag, rvalid, exp_v);
        end else if (exp_v && rdata !== exp_d) begin
            n_bad++;
            $display("FAIL %s: rdata=%h expected %h", tag, rdata, exp_d);
        end
    endtask

    task automatic step(input logic l, input logic w, input logic c0n,
                        input logic c1v, input logic c2n, input logic [AW-1:0] a,
                        input logic [LN-1:0] bwn, input logic ckn);
        ld_n = l; we_n = w; ce0_n = c0n; ce1 = c1v; ce2_n = c2n;
        addr = a; bw_n = bwn; cke_n = ckn;
        wdata = gen(wd_k); wd_k++;
        @(posedge clk);
        #1;
        if (!ckn) model_edge(l, w, c0n, c1v, c2n, a, bwn);
        @(negedge clk);
        check_out();
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [LN-1:0] bwn);
        step(0, 0, 0, 1, 0, a, bwn, 0);
    endtask
    task automatic rd(input logic [AW-1:0] a);
        step(0, 1, 0, 1, 0, a, '1, 0);
    endtask
    task automatic adv(input logic w, input logic [LN-1:0] bwn);
        step(1, w, 0, 1, 0, '0, bwn, 0);
    endtask
    task automatic nop();
        step(0, 1, 1, 1, 0, '0, '1, 0);
    endtask
    task automatic stall();
        step(1, 0, 0, 1, 0, '0, '0, 1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cke_n = 1'b0; ld_n = 1'b0; we_n = 1'b1; ce0_n = 1'b1;
        ce1 = 1'b1; ce2_n = 1'b0; addr = '0; bw_n = '1; wdata = '0; linear = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        tag = "R11";
        n_cmp++;
        if (rvalid !== 1'b0 || rdata !== '0) begin
            n_bad++;
            $display("FAIL R11: rvalid=%0b rdata=%h expected 0 0", rvalid, rdata);
        end
        nop(); nop();

        // R1 then R2: fill every word, read every word, back to back
        tag = "R1";
        for (int a = 0; a < DEPTH; a++) wr(AW'(a), '0);
        tag = "R2";
        for (int a = 0; a < DEPTH; a++) rd(AW'(a));
        nop(); nop();

        // R6: all strobe patterns on one word
        tag = "R6";
        for (int p = 0; p < 16; p++) begin
            wr(AW'(3), LN'(p));
            nop(); nop();
            rd(AW'(3));
            nop(); nop();
        end

        // R7, R12: alternate write and read of the same words on consecutive edges
        tag = "R7 R12";
        for (int a = 0; a < DEPTH; a++) begin
            wr(AW'(a), LN'(a));
            rd(AW'(a));
        end
        for (int a = 0; a < 8; a++) begin
            rd(AW'(a ^ 5));
            wr(AW'(a ^ 5), '0);
        end
        nop(); nop();

        // R4, R10: every chip-enable combination for writes and reads
        tag = "R4 R10";
        for (int c = 0; c < 8; c++) begin
            step(0, 0, c[0], c[1], c[2], AW'(5), '0, 0);
            nop(); nop();
            rd(AW'(5));
            step(0, 1, c[0], c[1], c[2], AW'(5), '1, 0);
            nop(); nop();
        end

        // R8 with R3: linear bursts from unaligned starts, we_n toggled mid-burst
        linear = 1'b1;
        nop(); nop();
        tag = "R8 R3";
        for (int s = 0; s < 4; s++) begin
            wr(AW'(8 + s), '0);
            adv(1, '0); adv(0, 4'b0101); adv(1, '0);
            rd(AW'(8 + s));
            adv(0, '0); adv(1, '0); adv(0, '0);
            nop(); nop();
        end

        // R9 with R3: interleaved bursts
        linear = 1'b0;
        nop(); nop();
        tag = "R9 R3";
        for (int s = 0; s < 4; s++) begin
            wr(AW'(4 + s), '0);
            adv(1, 4'b1010); adv(0, '0); adv(1, '0);
            rd(AW'(4 + s));
            adv(0, '0); adv(0, '0); adv(1, '0);
            nop(); nop();
        end
        linear = 1'b1;
        nop(); nop();

        // R5: stalls while reads and writes are in flight
        tag = "R5";
        wr(AW'(2), '0);
        stall();
        rd(AW'(2));
        stall(); stall();
        wr(AW'(2), 4'b0011);
        stall();
        rd(AW'(2));
        stall(); stall(); stall();
        nop(); nop(); nop();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule